// File: doc/BRIEF.md
# Six-Pin General-Purpose I/O Port

This block is a memory-mapped I/O port for six pads. It holds three writable control registers: pin direction, output data and open-drain select. It also provides a read-only view that reports the level of each pin. A simple synchronous register bus reaches all four locations through a two-bit offset, a write strobe, write data and combinational read data.

For each pad the block drives an output enable, an output level and a PMOS enable, and it samples the pad input level. Inputs pass through a two-stage synchronizer before software can read them.

The block follows four reset and standby conditions. Power-on reset and hardware standby clear the control registers. Manual reset and software standby leave every register as it was and block bus writes.

Top module: `gpio6_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the direction, data and open-drain registers clear to zero and the pin synchronizer clears to zero. After reset, reads at offsets 0, 1, 2 and 3 return 0 in bits 5..0, and `pad_oe`, `pad_out` and `pad_pmos_en` are all 0.
- R2: A write with `bus_we`=1 loads `bus_wdata[5:0]` at the next clock edge into one register, selected by offset: 0 = direction, 1 = output data, 3 = open-drain select. Reads at those offsets return the register in bits 5..0 in the same cycle. Write data bits 7..6 have no effect.
- R3: At each clock edge where `hw_stby` is 1, all three writable registers clear to zero, and any bus write in that cycle is dropped.
- R4: While `man_rst` or `sw_stby` is 1 (and `hw_stby` is 0), bus writes are ignored and all three registers keep their contents.
- R5: A write to offset 2 (pin state) changes no register.
- R6: A read at offset 2 returns, for each bit i in 5..0, the data register bit when direction bit i is 1, and the synchronized pin level when direction bit i is 0.
- R7: The pin level seen by an offset-2 read is `pad_in` as it stood at the clock edge two edges earlier.
- R8: When direction bit i is 0, `pad_oe[i]`, `pad_out[i]` and `pad_pmos_en[i]` are 0.
- R9: With direction bit i = 1 and open-drain bit i = 0 (push-pull), `pad_oe[i]`=1, `pad_pmos_en[i]`=1 and `pad_out[i]` equals data bit i.
- R10: With direction bit i = 1 and open-drain bit i = 1, `pad_pmos_en[i]`=0. A data bit of 1 gives `pad_oe[i]`=0. A data bit of 0 gives `pad_oe[i]`=1 with `pad_out[i]`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby; clears control registers |
| man_rst | input | 1 | Manual reset; registers hold, writes blocked |
| sw_stby | input | 1 | Software standby; registers hold, writes blocked |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, combinational |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output level |
| pad_pmos_en | output | 6 | Per-pin pull-up driver enable |

## Verification
The bench targets the following corner cases:
- Writes issued during manual reset or software standby. A design that let them through would corrupt state that must survive those conditions.
- Writes issued while hardware standby is high. A design that let the write win over the clear would leave a nonzero register.
- Writes aimed at the read-only offset. A decoder that aliased offset 2 onto a writable register would be caught.
- Offset-2 reads with mixed direction bits, and input changes checked one edge and then two edges later. These expose a mux that picks the wrong source, and a synchronizer that is one stage short or too long.
- Open-drain pins with a data bit of 1. A design that still enabled the pull-up or the output would drive the pin high.

// File: rtl/gpio6_pkg.sv
// Package: shared constants and the register-offset encoding of the port.
// Assumes a two-bit offset space with all four offsets decoded.
package gpio6_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_ODRN = 2'd3
    } reg_sel_e;

    // Per-pin drive mode as decoded from direction and open-drain bits.
    typedef enum logic [1:0] {
        MODE_INPUT = 2'd0,
        MODE_PUSH  = 2'd1,
        MODE_OPEN  = 2'd2
    } pin_mode_e;

    function automatic pin_mode_e pin_mode(input logic dir_bit, input logic od_bit);
        if (!dir_bit)     return MODE_INPUT;
        else if (!od_bit) return MODE_PUSH;
        else              return MODE_OPEN;
    endfunction

endpackage

// File: rtl/gpio6_ctl_reg.sv
// Module: one writable control register of the port.
// Clears on power-on reset (synchronous, active low) or while the clear
// input is high; otherwise loads when load is high and holds otherwise.
// Assumes the caller already blocked loads for hold conditions.
module gpio6_ctl_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Register update: reset or clear dominates, then load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/gpio6_in_sync.sv
// Module: multi-stage synchronizer for the pad input levels.
// Each stage is a bank of flops; the last stage is the synchronized level.
// Assumes STAGES >= 1; only power-on reset clears the chain.
module gpio6_in_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw pad level.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            // Later stage: shift from the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio6_pad_drv.sv
// Module: per-pin pad drive decode.
// Turns direction, data and open-drain bits into output enable, output
// level and pull-up enable. Purely combinational; assumes registered inputs.
module gpio6_pad_drv
    import gpio6_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] odrn_q,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pmos_en
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_mode_e mode;

        assign mode = pin_mode(dir_q[i], odrn_q[i]);

        // Drive decode for one pin according to its mode.
        always_comb begin
            unique case (mode)
                MODE_PUSH: begin
                    pad_oe[i]      = 1'b1;
                    pad_out[i]     = data_q[i];
                    pad_pmos_en[i] = 1'b1;
                end
                MODE_OPEN: begin
                    pad_oe[i]      = ~data_q[i];
                    pad_out[i]     = 1'b0;
                    pad_pmos_en[i] = 1'b0;
                end
                default: begin
                    pad_oe[i]      = 1'b0;
                    pad_out[i]     = 1'b0;
                    pad_pmos_en[i] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/gpio6_rd_mux.sv
// Module: read-data select for the register bus.
// Picks the addressed register; the pin view merges data and synchronized
// pin level per bit by direction. Bits above the pin count read as zero.
module gpio6_rd_mux
    import gpio6_pkg::*;
#(
    parameter int W     = 6,
    parameter int BUS_W = 8
) (
    input  logic [ADDR_W-1:0] sel,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      data_q,
    input  logic [W-1:0]      odrn_q,
    input  logic [W-1:0]      pin_sync,
    output logic [BUS_W-1:0]  rdata
);

    logic [W-1:0] pin_view;

    // Per-bit merge of the output latch and the live (synchronized) level.
    always_comb begin
        for (int i = 0; i < W; i++) begin
            pin_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
        end
    end

    // Offset decode for the read path.
    always_comb begin
        rdata = '0;
        unique case (reg_sel_e'(sel))
            SEL_DIR:  rdata[W-1:0] = dir_q;
            SEL_DATA: rdata[W-1:0] = data_q;
            SEL_PIN:  rdata[W-1:0] = pin_view;
            SEL_ODRN: rdata[W-1:0] = odrn_q;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio6_port.sv
// Module: top of the six-pin I/O port.
// Decodes bus writes, holds direction/data/open-drain registers, synchronizes
// pad inputs and drives the pad controls. Assumes PINS <= BUS_W and that
// reset and standby inputs are synchronous to clk.
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int PINS        = 6,
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              man_rst,
    input  logic              sw_stby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pmos_en
);

    logic            wr_ok;
    logic            ld_dir;
    logic            ld_data;
    logic            ld_odrn;
    logic [PINS-1:0] wr_bits;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] odrn_q;
    logic [PINS-1:0] pin_sync;

    // Write gating: hold conditions and hardware standby block the bus.
    always_comb begin
        wr_ok   = bus_we & ~man_rst & ~sw_stby & ~hw_stby;
        ld_dir  = wr_ok & (reg_sel_e'(bus_addr) == SEL_DIR);
        ld_data = wr_ok & (reg_sel_e'(bus_addr) == SEL_DATA);
        ld_odrn = wr_ok & (reg_sel_e'(bus_addr) == SEL_ODRN);
        wr_bits = bus_wdata[PINS-1:0];
    end

    gpio6_ctl_reg #(.W(PINS)) i_dir (
        .clk(clk), .rst_n(rst_n), .clear(hw_stby),
        .load(ld_dir), .d(wr_bits), .q(dir_q)
    );

    gpio6_ctl_reg #(.W(PINS)) i_data (
        .clk(clk), .rst_n(rst_n), .clear(hw_stby),
        .load(ld_data), .d(wr_bits), .q(data_q)
    );

    gpio6_ctl_reg #(.W(PINS)) i_odrn (
        .clk(clk), .rst_n(rst_n), .clear(hw_stby),
        .load(ld_odrn), .d(wr_bits), .q(odrn_q)
    );

    gpio6_in_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
    );

    gpio6_pad_drv #(.W(PINS)) i_drv (
        .dir_q(dir_q), .data_q(data_q), .odrn_q(odrn_q),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pmos_en(pad_pmos_en)
    );

    gpio6_rd_mux #(.W(PINS), .BUS_W(BUS_W)) i_rd (
        .sel(bus_addr), .dir_q(dir_q), .data_q(data_q), .odrn_q(odrn_q),
        .pin_sync(pin_sync), .rdata(bus_rdata)
    );

endmodule

// File: rtl/gpio6_port_chk.sv
// Module: assertion checker bound to gpio6_port.
// Observes ports and the three control registers; assumes a two-stage
// synchronizer for the readback-latency property.
module gpio6_port_chk
    import gpio6_pkg::*;
#(
    parameter int PINS  = 6,
    parameter int BUS_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              man_rst,
    input logic              sw_stby,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_pmos_en,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   data_q,
    input logic [PINS-1:0]   odrn_q
);

    logic [1:0] run_cnt;

    // Count consecutive edges out of reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_DIR && !man_rst && !sw_stby && !hw_stby)
        |=> dir_q == $past(bus_wdata[PINS-1:0])); // R2

    AST_STBY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (dir_q == '0 && data_q == '0 && odrn_q == '0)); // R3

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((man_rst || sw_stby) && !hw_stby)
        |=> ($stable(dir_q) && $stable(data_q) && $stable(odrn_q))); // R4

    AST_PIN_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_PIN && !hw_stby)
        |=> ($stable(dir_q) && $stable(data_q) && $stable(odrn_q))); // R5

    AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2 && bus_addr == SEL_PIN)
        |-> (((bus_rdata[PINS-1:0] ^ $past(pad_in, 2)) & ~dir_q) == '0)); // R7

    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pmos_en) & ~dir_q) == '0); // R8

    AST_PUSH_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~odrn_q) & ~(pad_oe & pad_pmos_en)) == '0); // R9

    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe & pad_out) | pad_pmos_en) & odrn_q) == '0); // R10

endmodule

bind gpio6_port gpio6_port_chk #(.PINS(PINS), .BUS_W(BUS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst),
    .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pmos_en(pad_pmos_en),
    .dir_q(dir_q), .data_q(data_q), .odrn_q(odrn_q)
);

// File: tb/test_gpio6_port.sv
// Bench for gpio6_port: directed corner cases, then seeded random traffic,
// all checked against a behavioural model held in the bench.
module test_gpio6_port;

    localparam int CLK_NS = 10;
    localparam int N      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       man_rst = 1'b0;
    logic       sw_stby = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_oe;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_pmos_en;

    int total = 0;
    int bad   = 0;

    // Behavioural model state.
    logic [N-1:0] m_dir = '0, m_dat = '0, m_od = '0, m_s1 = '0, m_s2 = '0;

    gpio6_port i_gpio6_port (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .man_rst(man_rst),
        .sw_stby(sw_stby), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pmos_en(pad_pmos_en)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Model update from the requirements at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir <= '0; m_dat <= '0; m_od <= '0; m_s1 <= '0; m_s2 <= '0;
        end else begin
            m_s1 <= pad_in;
            m_s2 <= m_s1;
            if (hw_stby) begin
                m_dir <= '0; m_dat <= '0; m_od <= '0;
            end else if (bus_we && !man_rst && !sw_stby) begin
                case (bus_addr)
                    2'd0: m_dir <= bus_wdata[N-1:0];
                    2'd1: m_dat <= bus_wdata[N-1:0];
                    2'd3: m_od  <= bus_wdata[N-1:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [N-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_dir;
            2'd1:    return m_dat;
            2'd2:    return (m_dir & m_dat) | (~m_dir & m_s2);
            default: return m_od;
        endcase
    endfunction

    // Expected {oe, out, pmos} for pin i.
    function automatic logic [2:0] exp_pad(input int i);
        if (!m_dir[i])     return 3'b000;
        else if (!m_od[i]) return {1'b1, m_dat[i], 1'b1};
        else               return m_dat[i] ? 3'b000 : 3'b100;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check combinational outputs 1 ns later.
    task automatic tick(input logic rst, input logic hw, input logic man, input logic sw,
                        input logic we, input logic [1:0] a, input logic [7:0] wd,
                        input logic [N-1:0] pin, input string tag);
        @(negedge clk);
        rst_n = rst; hw_stby = hw; man_rst = man; sw_stby = sw;
        bus_we = we; bus_addr = a; bus_wdata = wd; pad_in = pin;
        #1;
        check(tag, {2'b00, bus_rdata[N-1:0]}, {2'b00, exp_read(a)});
        for (int i = 0; i < N; i++) begin
            string ptag;
            ptag = !m_dir[i] ? "R8" : (!m_od[i] ? "R9" : "R10");
            check(ptag, {5'd0, pad_oe[i], pad_out[i], pad_pmos_en[i]}, {5'd0, exp_pad(i)});
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [N-1:0] pin, input string tag);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, pin, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [N-1:0] pin);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a, d, pin, "R2");
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_NS * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        for (int k = 0; k < 3; k++) tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 6'h2d, "R1");
        for (int a = 0; a < 4; a++) rd(2'(a), 6'h00, "R1");
        check("R1", {2'b00, pad_oe}, 8'h00);

        // R2: writes with upper bits set, read back
        wr(2'd0, 8'hff, 6'h00);
        wr(2'd1, 8'hea, 6'h00);
        wr(2'd3, 8'h45, 6'h00);
        rd(2'd0, 6'h00, "R2"); check("R2", bus_rdata, 8'h3f);
        rd(2'd1, 6'h00, "R2"); check("R2", bus_rdata, 8'h2a);
        rd(2'd3, 6'h00, "R2"); check("R2", bus_rdata, 8'h05);

        // R5: write to the pin-state offset, registers unchanged
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 6'h00, "R5");
        rd(2'd0, 6'h00, "R5"); check("R5", bus_rdata, 8'h3f);
        rd(2'd1, 6'h00, "R5"); check("R5", bus_rdata, 8'h2a);
        rd(2'd3, 6'h00, "R5"); check("R5", bus_rdata, 8'h05);

        // R4: writes during manual reset and software standby are ignored
        tick(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 8'h00, 6'h00, "R4");
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 8'h00, 6'h00, "R4");
        tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 8'h3f, 6'h00, "R4");
        rd(2'd0, 6'h00, "R4"); check("R4", bus_rdata, 8'h3f);
        rd(2'd1, 6'h00, "R4"); check("R4", bus_rdata, 8'h2a);
        rd(2'd3, 6'h00, "R4"); check("R4", bus_rdata, 8'h05);

        // R6: mixed direction, pin view merges data and pins
        wr(2'd0, 8'h0f, 6'h30);
        rd(2'd2, 6'h30, "R6");
        rd(2'd2, 6'h30, "R6");
        rd(2'd2, 6'h30, "R6"); check("R6", bus_rdata, 8'h3a);

        // R7: two-edge latency of the input path
        wr(2'd0, 8'h00, 6'h00);
        rd(2'd2, 6'h00, "R7");
        rd(2'd2, 6'h00, "R7"); check("R7", bus_rdata, 8'h00);
        rd(2'd2, 6'h15, "R7"); check("R7", bus_rdata, 8'h00);
        rd(2'd2, 6'h15, "R7"); check("R7", bus_rdata, 8'h00);
        rd(2'd2, 6'h15, "R7"); check("R7", bus_rdata, 8'h15);

        // R10 and R9: open-drain and push-pull pads
        wr(2'd0, 8'h3f, 6'h00);
        wr(2'd3, 8'h07, 6'h00);
        wr(2'd1, 8'h05, 6'h00);
        rd(2'd1, 6'h00, "R10");
        check("R10", {2'b00, pad_pmos_en}, 8'h38);
        check("R10", {2'b00, pad_oe}, 8'h3a);

        // R3: hardware standby clears and beats a concurrent write
        tick(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h3f, 6'h00, "R3");
        rd(2'd1, 6'h00, "R3"); check("R3", bus_rdata, 8'h00);
        rd(2'd0, 6'h00, "R3"); check("R3", bus_rdata, 8'h00);
        rd(2'd3, 6'h00, "R3"); check("R3", bus_rdata, 8'h00);

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] a;
            int r;
            r = $urandom_range(0, 99);
            a = 2'($urandom_range(0, 3));
            tick((r != 0), (r == 1), (r >= 2 && r < 7), (r >= 7 && r < 11),
                 1'($urandom_range(0, 1)), a, 8'($urandom),
                 N'($urandom), (a == 2'd2) ? "R6" : "R2");
        end

        // R1: reset in mid-run clears everything again.
        wr(2'd0, 8'h3f, 6'h3f);
        tick(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 6'h3f, "R1");
        rd(2'd0, 6'h3f, "R1"); check("R1", bus_rdata, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule